// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Interface

This block is the digital front end of a four-channel, 12-bit voltage-output converter. A host on a 12-bit parallel bus addresses one channel at a time. It can load that channel's staging (input) register, read the staging register back, or load it so that the value also goes straight to the channel's live (output) register. A separate active-low load strobe, used with the chip select high, copies all four staging registers into the live registers in the same clock cycle. This lets the four analog outputs change together. The four live codes leave the block as one flat vector for the converter cores.

The block is synchronous to one clock and samples its controls on every rising edge. It has no back-pressure: every cycle is accepted, and a command is acted on in the cycle it is presented. The tri-state bus is split into an input word, an output word and an output-enable flag. An active-low reset forces every register to a reset code chosen by parameter, either midscale or zero scale. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `qdac_regif`

## Requirements
- R1: While `rst_n` is low, all staging and live registers hold the reset code at once, without waiting for a clock edge. The reset code is 12'h800 when `MIDSCALE`=1 (the default) and 12'h000 when `MIDSCALE`=0. After `rst_n` rises, commands take effect from the third rising edge onward.
- R2: `addr` value 0, 1, 2 and 3 selects channel 0, 1, 2 and 3. Channel i appears on `out_codes[12*i+11:12*i]`, and bit 11 is the MSB.
- R3: With `sel_n`=0, `rd_wr`=0 and `ld_n`=0, the next rising edge loads `din` into both the staging and the live register of the addressed channel. The other channels are unchanged.
- R4: With `sel_n`=0, `rd_wr`=0 and `ld_n`=1, the next rising edge loads `din` into the addressed staging register only. No live register changes.
- R5: With `sel_n`=0 and `rd_wr`=1, `dout_oe` is 1 and `dout` shows the addressed staging register in the same cycle. A read never changes any staging register.
- R6: With `sel_n`=1 and `ld_n`=0, the next rising edge copies every staging register into its live register, all in the same cycle.
- R7: With `sel_n`=1 and `ld_n`=1, no register changes, whatever `din`, `addr` and `rd_wr` are.
- R8: A read with `ld_n`=0 acts as a readback (R5) and, at the next rising edge, as a global copy (R6). The staging registers stay unchanged.
- R9: `dout_oe` is 1 only when `sel_n`=0 and `rd_wr`=1. Otherwise `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ld_n | input | 1 | Active-low load strobe |
| addr | input | 2 | Channel select |
| din | input | 12 | Bus data from the host |
| dout | output | 12 | Readback data |
| dout_oe | output | 1 | Bus drive enable, high during a selected read |
| out_codes | output | 48 | Four live codes, channel 0 in the low bits |

## Verification
Each of the four channels is written with a distinct value, including all-ones, all-zeros, single-LSB and midscale codes. These values would show a swapped address decode or a swapped output slice. The bench alternates staging-only writes with write-through writes, so a live register that follows its staging register without a load command is caught. Global copies are issued both as idle-select cycles and as reads with the load strobe low, which separates the global path from the single-channel path. Idle cycles with noisy data and address, and a reset asserted in the middle of a cycle, show whether the hold and asynchronous-reset behaviour is correct.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WR_THRU,
    OP_WR_STAGE,
    OP_RD,
    OP_RD_LOAD,
    OP_LOAD_ALL
  } op_e;

  function automatic op_e classify(input logic sel_n, input logic rd_wr, input logic ld_n);
    op_e op;
    if (!sel_n) begin
      if (!rd_wr) op = ld_n ? OP_WR_STAGE : OP_WR_THRU;
      else        op = ld_n ? OP_RD : OP_RD_LOAD;
    end else begin
      op = ld_n ? OP_IDLE : OP_LOAD_ALL;
    end
    return op;
  endfunction

endpackage

// File: rtl/qdac_rst_sync.sv
module qdac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_q = shreg[STAGES-1];
endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  logic          sel_n,
  input  logic          rd_wr,
  input  logic          ld_n,
  input  logic [AW-1:0] addr,
  output logic [NCH-1:0] stage_we,
  output logic [NCH-1:0] live_we,
  output logic          rd_en
);
  op_e  op;
  logic wr_any, thru, global_ld;

  always_comb begin
    op        = classify(sel_n, rd_wr, ld_n);
    wr_any    = (op == OP_WR_THRU) || (op == OP_WR_STAGE);
    thru      = (op == OP_WR_THRU);
    global_ld = (op == OP_LOAD_ALL) || (op == OP_RD_LOAD);
    rd_en     = (op == OP_RD) || (op == OP_RD_LOAD);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_en
    assign stage_we[i] = wr_any && (addr == AW'(i));
    assign live_we[i]  = global_ld || (thru && (addr == AW'(i)));
  end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
  parameter int         DW       = 12,
  parameter logic [11:0] RST_CODE = 12'h800
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          stage_we,
  input  logic          live_we,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] stage_q,
  output logic [DW-1:0] live_q
);
  localparam logic [DW-1:0] RCODE = DW'(RST_CODE);
  logic [DW-1:0] live_d;

  assign live_d = stage_we ? din : stage_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      stage_q <= RCODE;
      live_q  <= RCODE;
    end else begin
      if (stage_we) stage_q <= din;
      if (live_we)  live_q  <= live_d;
    end
  end

  // R3
  write_thru_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (stage_we && live_we) |=> (live_q == stage_q));

  // R4
  stage_only_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (stage_we && !live_we) |=> $stable(live_q));

  // R6
  global_copy_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (live_we && !stage_we) |=> (live_q == $past(stage_q)));

  // R5
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !stage_we |=> $stable(stage_q));

  // R1
  reset_code_chk: assert property (@(posedge clk)
    $rose(rst_q) |-> (stage_q == RCODE && live_q == RCODE));
endmodule

// File: rtl/qdac_regif.sv
module qdac_regif #(
  parameter int NCH       = 4,
  parameter int DW        = 12,
  parameter bit MIDSCALE  = 1'b1,
  localparam int AW       = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic            rd_wr,
  input  logic            ld_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   din,
  output logic [DW-1:0]   dout,
  output logic            dout_oe,
  output logic [NCH*DW-1:0] out_codes
);
  localparam logic [11:0] RST_CODE = MIDSCALE ? 12'h800 : 12'h000;

  logic            rst_q;
  logic [NCH-1:0]  stage_we, live_we;
  logic            rd_en;
  logic [DW-1:0]   stage_arr [NCH];

  qdac_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  qdac_decode #(.NCH(NCH)) u_dec (
    .sel_n(sel_n), .rd_wr(rd_wr), .ld_n(ld_n), .addr(addr),
    .stage_we(stage_we), .live_we(live_we), .rd_en(rd_en)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    qdac_chan #(.DW(DW), .RST_CODE(RST_CODE)) u_ch (
      .clk(clk), .rst_q(rst_q),
      .stage_we(stage_we[i]), .live_we(live_we[i]), .din(din),
      .stage_q(stage_arr[i]), .live_q(out_codes[i*DW +: DW])
    );
  end

  assign dout_oe = rd_en;
  assign dout    = rd_en ? stage_arr[addr] : '0;

  // R9
  oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    dout_oe |-> (!sel_n && rd_wr));

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(!sel_n && rd_wr) |-> (dout == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_n && ld_n) |=> $stable(out_codes));
endmodule

// File: tb/qdac_regif_test.sv
module qdac_regif_test;
  localparam logic [11:0] RST = 12'h800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, rd_wr = 1'b0, ld_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [11:0] din = '0;
  logic [11:0] dout;
  logic        dout_oe;
  logic [47:0] out_codes;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [11:0] stg_m [4];
  logic [11:0] liv_m [4];

  qdac_regif uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr), .ld_n(ld_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .out_codes(out_codes)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_live(input string req);
    for (int i = 0; i < 4; i++) check(req, out_codes[i*12 +: 12], liv_m[i]);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin stg_m[i] = RST; liv_m[i] = RST; end
  endtask

  // One bus cycle, driven after a falling edge, checked before and after the rising edge
  task automatic bus(input logic s, input logic r, input logic l,
                     input logic [1:0] a, input logic [11:0] d, input string req);
    sel_n = s; rd_wr = r; ld_n = l; addr = a; din = d;
    #1;
    check({req, "/R9 oe"}, {11'd0, dout_oe}, {11'd0, (!s && r)});
    if (!s && r) check({req, "/R5 readback"}, dout, stg_m[a]);
    else         check({req, "/R9 quiet"}, dout, 12'h000);
    @(posedge clk);
    if (!s && !r) begin
      stg_m[a] = d;
      if (!l) liv_m[a] = d;
    end else if (!l) begin
      for (int i = 0; i < 4; i++) liv_m[i] = stg_m[i];
    end
    @(negedge clk);
    sel_n = 1'b1; ld_n = 1'b1; rd_wr = 1'b0;
    check_live(req);
  endtask

  task automatic readback_all(input string req);
    for (int i = 0; i < 4; i++) bus(1'b0, 1'b1, 1'b1, 2'(i), 12'h5A5, req);
  endtask

  task automatic t_reset_state();
    check_live("R1 reset live");
    readback_all("R1 reset stage");
  endtask

  task automatic t_write_thru();
    bus(1'b0, 1'b0, 1'b0, 2'd0, 12'hFFF, "R3 ch0 R2");
    bus(1'b0, 1'b0, 1'b0, 2'd1, 12'h000, "R3 ch1 R2");
    bus(1'b0, 1'b0, 1'b0, 2'd2, 12'h001, "R3 ch2 R2");
    bus(1'b0, 1'b0, 1'b0, 2'd3, 12'hA5C, "R3 ch3 R2");
    readback_all("R3 readback");
  endtask

  task automatic t_stage_only();
    bus(1'b0, 1'b0, 1'b1, 2'd3, 12'h123, "R4 ch3");
    bus(1'b0, 1'b0, 1'b1, 2'd0, 12'h800, "R4 ch0");
    bus(1'b0, 1'b0, 1'b1, 2'd2, 12'hFFE, "R4 ch2");
    readback_all("R4 readback");
  endtask

  task automatic t_global();
    bus(1'b1, 1'b0, 1'b0, 2'd1, 12'h777, "R6 global");
    readback_all("R6 readback");
  endtask

  task automatic t_idle();
    bus(1'b0, 1'b0, 1'b1, 2'd1, 12'h3C3, "R7 prep");
    for (int k = 0; k < 4; k++)
      bus(1'b1, 1'(k & 1), 1'b1, 2'(k), 12'(12'h111 * (k + 3)), "R7 idle");
    readback_all("R7 readback");
  endtask

  task automatic t_read_load();
    bus(1'b0, 1'b0, 1'b1, 2'd0, 12'h0F0, "R8 prep");
    bus(1'b0, 1'b0, 1'b1, 2'd3, 12'hF0F, "R8 prep");
    bus(1'b0, 1'b1, 1'b0, 2'd2, 12'hBAD, "R8 read+load");
    readback_all("R8 readback");
  endtask

  task automatic t_async_reset();
    bus(1'b0, 1'b0, 1'b0, 2'd1, 12'h999, "R1 prep");
    #1;
    rst_n = 1'b0;
    sel_n = 1'b0; rd_wr = 1'b1; addr = 2'd1;
    #0.5;
    model_reset();
    check_live("R1 async");
    check("R1 async stage", dout, RST);
    @(negedge clk);
    sel_n = 1'b1; rd_wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    t_reset_state();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    t_reset_state();
    t_write_thru();
    t_stage_only();
    t_global();
    t_idle();
    t_read_load();
    t_async_reset();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule